// File: doc/BRIEF.md
# Serial Receive Queue with Trigger Level and Idle Timeout

This block sits behind a serial receiver. It holds incoming bytes until the bus side reads them. Bytes come in on a strobe-qualified data input, and only while receiving is enabled. They are kept in a ring of `DEPTH` entries. A read strobe removes the oldest byte, and the byte is presented combinationally on `pop_data`.

Software chooses one of four fill thresholds. When the threshold is reached, `data_ready` rises, and if interrupts are enabled, `rx_irq` rises as well. A small amount of data can sit below the threshold. To stop it waiting forever, every arrival that leaves the queue short of the threshold restarts an idle timer. The timer counts `TIMEOUT_BITS` pulses of a bit-period tick. If it runs out, it raises the same flag and interrupt. A clear strobe drops all queued data at once.

Top module: `rx_trig_fifo`

## Requirements
- R1: After reset the queue is empty. `fill_count` is 0, `data_ready` and `rx_irq` are low, and `pop_data` reads 8'hFF.
- R2: Bytes are popped in the order they were accepted. The ring wraps around its end, and it holds at most 16 bytes with default parameters.
- R3: `trig_sel` values 0, 1, 2 and 3 select thresholds of 1, 4, 8 and 14 bytes. `data_ready` goes high on the clock edge of the arrival that makes the count equal to or greater than the threshold.
- R4: A `fifo_clear` pulse makes `fill_count` 0 and `data_ready` low on that edge. Afterwards `pop_data` reads 8'hFF.
- R5: An arrival that leaves the count below the threshold restarts the idle timer at 15 ticks. The edge that samples the 15th `bit_tick` pulse after that arrival sets `data_ready`, and with `rxi_en` high it also sets `rx_irq`. Fewer than 15 pulses do not set them.
- R6: An arrival that reaches the threshold while `rxi_en` is high raises `rx_irq` and cancels a pending idle timeout. Later ticks then do not set the flag again.
- R7: A pop while the queue is not empty decrements `fill_count`. If the new count is below the threshold, `data_ready` goes low.
- R8: A byte offered while `rx_enable` is low, or while the queue is full, is dropped. The count and contents stay unchanged.
- R9: `rx_irq` is low on the edge after any cycle with `rxi_en` low. A pop does not lower it.
- R10: A pop on an empty queue reads 8'hFF and changes nothing. An arrival and a pop in the same cycle leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Incoming byte strobe |
| rx_data | input | 8 | Incoming byte |
| rx_enable | input | 1 | Receive enable; bytes ignored while low |
| pop | input | 1 | Read strobe; removes the oldest byte |
| pop_data | output | 8 | Oldest byte, or 8'hFF when empty |
| trig_sel | input | 2 | Threshold select (1/4/8/14) |
| fifo_clear | input | 1 | Empties the queue |
| rxi_en | input | 1 | Receive interrupt enable |
| bit_tick | input | 1 | One pulse per bit period |
| data_ready | output | 1 | Threshold reached or idle timeout expired |
| rx_irq | output | 1 | Receive interrupt |
| fill_count | output | 5 | Bytes held |

## Verification
The embedded properties assume that `trig_sel` is held steady while an arrival is judged against the threshold. They also assume that `bit_tick` is a single-cycle pulse. The stimulus changes `trig_sel` only while the queue is empty or idle, and it drives each tick high for exactly one cycle. Clear is given priority over a simultaneous arrival or pop, and the properties are written with that priority in mind. Every other input is free to vary, including a full queue receiving more bytes and a pop arriving together with a push.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   // Threshold lookup shared by the top and its properties.
   function automatic int unsigned trig_level(
      input logic [1:0]  sel,
      input int unsigned l0,
      input int unsigned l1,
      input int unsigned l2,
      input int unsigned l3);
      case (sel)
         2'd0:    return l0;
         2'd1:    return l1;
         2'd2:    return l2;
         default: return l3;
      endcase
   endfunction
endpackage

// File: rtl/rxq_ring.sv
module rxq_ring #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned DW    = 8,
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic [DW-1:0]    din,
   input  logic             pop,
   output logic [DW-1:0]    dout,
   output logic [CNT_W-1:0] count,
   output logic             full
);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   logic [DW-1:0]    mem [DEPTH];
   logic [PTR_W-1:0] head, tail, head_inc, tail_inc;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         always_comb begin
            head_inc = head + 1'b1;
            tail_inc = tail + 1'b1;
         end
      end else begin : g_mod
         always_comb begin
            head_inc = (head == LAST) ? '0 : head + 1'b1;
            tail_inc = (tail == LAST) ? '0 : tail + 1'b1;
         end
      end
   endgenerate

   assign full = (count == CNT_W'(DEPTH));
   assign dout = (count == '0) ? '1 : mem[tail];

   always_ff @(posedge clk) begin
      if (push) mem[head] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head  <= '0;
         tail  <= '0;
         count <= '0;
      end else if (clr) begin
         head  <= '0;
         tail  <= '0;
         count <= '0;
      end else begin
         if (push) head <= head_inc;
         if (pop)  tail <= tail_inc;
         count <= count + CNT_W'(push) - CNT_W'(pop);
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH)); // R2
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !clr) |-> (count != '0)); // R10
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
   parameter int unsigned LIMIT = 15,
   localparam int unsigned TW = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic cancel,
   input  logic tick,
   output logic fire
);
   logic [TW-1:0] remain;

   assign fire = tick && (remain == TW'(1)) && !arm && !cancel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       remain <= '0;
      else if (cancel)                  remain <= '0;
      else if (arm)                     remain <= TW'(LIMIT);
      else if (tick && remain != '0)    remain <= remain - 1'b1;
   end

   AST_TMO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      remain <= TW'(LIMIT)); // R5
   AST_FIRE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (remain == '0)); // R5
   AST_CANCEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      cancel |=> !fire); // R6
endmodule

// File: rtl/rx_trig_fifo.sv
module rx_trig_fifo #(
   parameter int unsigned DEPTH        = 16,
   parameter int unsigned DW           = 8,
   parameter int unsigned TIMEOUT_BITS = 15,
   parameter int unsigned TRIG0        = 1,
   parameter int unsigned TRIG1        = 4,
   parameter int unsigned TRIG2        = 8,
   parameter int unsigned TRIG3        = 14,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_valid,
   input  logic [DW-1:0]    rx_data,
   input  logic             rx_enable,
   input  logic             pop,
   output logic [DW-1:0]    pop_data,
   input  logic [1:0]       trig_sel,
   input  logic             fifo_clear,
   input  logic             rxi_en,
   input  logic             bit_tick,
   output logic             data_ready,
   output logic             rx_irq,
   output logic [CNT_W-1:0] fill_count
);
   import rxq_pkg::*;

   generate
      if (DEPTH < 2)
         $error("rx_trig_fifo: DEPTH must be at least 2");
      if (TRIG0 < 1 || TRIG3 > DEPTH || TRIG0 > TRIG1 || TRIG1 > TRIG2 || TRIG2 > TRIG3)
         $error("rx_trig_fifo: thresholds must rise within 1..DEPTH");
      if (TIMEOUT_BITS < 1)
         $error("rx_trig_fifo: TIMEOUT_BITS must be nonzero");
   endgenerate

   logic             full, push_ok, pop_ok, reach, fire, arm, cancel;
   logic [CNT_W-1:0] cnt_after, trig;

   always_comb trig = CNT_W'(trig_level(trig_sel, TRIG0, TRIG1, TRIG2, TRIG3));

   assign push_ok   = rx_valid && rx_enable && !full && !fifo_clear;
   assign pop_ok    = pop && (fill_count != '0) && !fifo_clear;
   assign cnt_after = fill_count + CNT_W'(push_ok) - CNT_W'(pop_ok);
   assign reach     = push_ok && (cnt_after >= trig);
   assign arm       = push_ok && !reach;
   assign cancel    = fifo_clear || (reach && rxi_en);

   rxq_ring #(.DEPTH(DEPTH), .DW(DW)) ring_i (
      .clk(clk), .rst_n(rst_n), .clr(fifo_clear),
      .push(push_ok), .din(rx_data), .pop(pop_ok),
      .dout(pop_data), .count(fill_count), .full(full));

   rxq_idle_timer #(.LIMIT(TIMEOUT_BITS)) timer_i (
      .clk(clk), .rst_n(rst_n), .arm(arm), .cancel(cancel),
      .tick(bit_tick), .fire(fire));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                data_ready <= 1'b0;
      else if (fifo_clear)                       data_ready <= 1'b0;
      else if (reach || fire)                    data_ready <= 1'b1;
      else if (pop_ok && cnt_after < trig)       data_ready <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                rx_irq <= 1'b0;
      else if (!rxi_en)          rx_irq <= 1'b0;
      else if (reach || fire)    rx_irq <= 1'b1;
   end

   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_clear |=> (fill_count == '0 && !data_ready)); // R4
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !rxi_en |=> !rx_irq); // R9
   AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_enable && !pop && !fifo_clear) |=> (fill_count == $past(fill_count))); // R8
   AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && fill_count == '0 && !(rx_valid && rx_enable)) |=> (fill_count == '0)); // R10
   AST_REACH_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_enable && !pop && !fifo_clear && fill_count < CNT_W'(DEPTH)
       && ({1'b0, fill_count} + 1'b1) >= {1'b0, trig}) |=> data_ready); // R3
   AST_POP_DECR: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && fill_count != '0 && !(rx_valid && rx_enable) && !fifo_clear)
      |=> (fill_count == $past(fill_count) - 1'b1)); // R7
endmodule

// File: tb/rx_trig_fifo_tb_top.sv
module rx_trig_fifo_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_valid = 1'b0, rx_enable = 1'b0, pop = 1'b0;
   logic [7:0] rx_data = 8'h00, pop_data;
   logic [1:0] trig_sel = 2'd0;
   logic       fifo_clear = 1'b0, rxi_en = 1'b0, bit_tick = 1'b0;
   logic       data_ready, rx_irq;
   logic [4:0] fill_count;

   int checks = 0, failures = 0;
   bit done = 1'b0;
   logic [7:0] exp_q[$];

   always #4 clk = ~clk;

   rx_trig_fifo dut_i (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_enable(rx_enable), .pop(pop), .pop_data(pop_data),
      .trig_sel(trig_sel), .fifo_clear(fifo_clear), .rxi_en(rxi_en),
      .bit_tick(bit_tick), .data_ready(data_ready), .rx_irq(rx_irq),
      .fill_count(fill_count));

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   // Driver: offers one byte; the scoreboard keeps it if it should be accepted.
   task automatic send(input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = b;
      if (rx_enable && exp_q.size() < 16) exp_q.push_back(b);
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   // Monitor: compares the presented byte with the scoreboard head, then pops.
   task automatic take(input string req);
      @(negedge clk);
      if (exp_q.size() > 0) check(req, pop_data, exp_q.pop_front());
      else                  check(req, pop_data, 8'hFF);
      pop = 1'b1;
      @(negedge clk);
      pop = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         bit_tick = 1'b1;
         @(negedge clk);
         bit_tick = 1'b0;
      end
   endtask

   initial begin
      #(200000 * 8);
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 count", fill_count, 0);
      check("R1 ready", data_ready, 0);
      check("R1 irq", rx_irq, 0);
      check("R1 data", pop_data, 8'hFF);

      rx_enable = 1'b1; rxi_en = 1'b1; trig_sel = 2'd0;
      send(8'h11);
      check("R3 level1 ready", data_ready, 1);
      check("R9 irq raised", rx_irq, 1);
      take("R2 first byte");
      check("R7 count", fill_count, 0);
      check("R7 ready low", data_ready, 0);
      check("R9 irq kept after pop", rx_irq, 1);
      @(negedge clk); rxi_en = 1'b0;
      @(negedge clk); rxi_en = 1'b1;
      check("R9 irq forced low", rx_irq, 0);

      // level 4
      trig_sel = 2'd1;
      send(8'h21); send(8'h22); send(8'h23);
      check("R3 below level4", data_ready, 0);
      send(8'h24);
      check("R3 level4 ready", data_ready, 1);
      check("R6 irq on reach", rx_irq, 1);
      take("R2 order");
      check("R7 below level", data_ready, 0);
      ticks(16);
      check("R6 timeout cancelled", data_ready, 0);
      for (int i = 0; i < 3; i++) take("R2 order");

      // idle timeout with restart
      @(negedge clk); rxi_en = 1'b0;
      @(negedge clk); rxi_en = 1'b1;
      send(8'h31);
      ticks(14);
      check("R5 before expiry", data_ready, 0);
      send(8'h32);
      ticks(14);
      check("R5 restarted", data_ready, 0);
      check("R5 irq not yet", rx_irq, 0);
      ticks(1);
      check("R5 expired ready", data_ready, 1);
      check("R5 expired irq", rx_irq, 1);
      take("R2 order"); take("R2 order");
      check("R7 empty", fill_count, 0);

      // level 8
      trig_sel = 2'd2;
      for (int i = 0; i < 7; i++) send(8'h40 + 8'(i));
      check("R3 below level8", data_ready, 0);
      send(8'h47);
      check("R3 level8 ready", data_ready, 1);
      for (int i = 0; i < 8; i++) take("R2 order");

      // level 14, fill and overflow
      trig_sel = 2'd3;
      for (int i = 0; i < 13; i++) send(8'h50 + 8'(i));
      check("R3 below level14", data_ready, 0);
      send(8'h5D);
      check("R3 level14 ready", data_ready, 1);
      send(8'h5E); send(8'h5F);
      check("R2 full", fill_count, 16);
      send(8'hEE);
      check("R8 full drop count", fill_count, 16);
      for (int i = 0; i < 16; i++) take("R2 wrap order");
      take("R10 empty pop");
      check("R10 empty count", fill_count, 0);

      // receive disabled
      trig_sel = 2'd0;
      rx_enable = 1'b0;
      send(8'h66);
      check("R8 disabled count", fill_count, 0);
      check("R8 disabled data", pop_data, 8'hFF);
      rx_enable = 1'b1;

      // clear
      trig_sel = 2'd1;
      send(8'h71); send(8'h72); send(8'h73); send(8'h74);
      check("R4 pre ready", data_ready, 1);
      @(negedge clk); fifo_clear = 1'b1;
      @(negedge clk); fifo_clear = 1'b0;
      exp_q.delete();
      check("R4 count", fill_count, 0);
      check("R4 ready", data_ready, 0);
      check("R4 data", pop_data, 8'hFF);

      // simultaneous push and pop
      trig_sel = 2'd0;
      send(8'h81);
      @(negedge clk);
      check("R10 simul data", pop_data, exp_q.pop_front());
      rx_valid = 1'b1; rx_data = 8'h82; pop = 1'b1;
      exp_q.push_back(8'h82);
      @(negedge clk);
      rx_valid = 1'b0; pop = 1'b0;
      check("R10 simul count", fill_count, 1);
      take("R2 after simul");
      check("R10 final count", fill_count, 0);

      finish_run();
   end
endmodule